// File: doc/BRIEF.md
# Correlated Double Sampling Sequencer

This block runs a measurement sequence over one shared analog path. For every iteration it points an external multiplexer at the signal input and has an external ADC convert it. It then points the multiplexer at the reference input and has the same ADC convert that. Because both samples pass through the same buffer and converter a short time apart, subtracting the reference from the signal removes the path's offset and most of its slow drift. The sequence is the same whether the converter runs single-ended or differential.

Each difference feeds a first-order recursive low-pass filter with a weight of 1/16, built from a subtract, an arithmetic shift and an add. The filter starts from zero at the beginning of each batch of 16 iterations. At the end of a batch the filtered value is presented with a one-cycle valid pulse, and the next batch starts on its own. An enable input gates the whole process. Dropping enable abandons the current batch without a result.

Top module: `cds_seq`

## Requirements
- R1: After a synchronous reset, `mux_sel`, `adc_start`, `adc_stop` and `batch_valid` are all 0 and `batch_value` is 0.
- R2: Within each iteration the signal is converted first with `mux_sel`=0, and the reference is converted second with `mux_sel`=1. `mux_sel` is settled at least one cycle before `adc_start` rises and does not change while a conversion is pending.
- R3: `adc_start` is a one-cycle pulse. After it, the block waits as long as needed for `adc_done`, and `adc_done` has no effect while no conversion is pending.
- R4: `adc_stop` is a one-cycle pulse, high in the cycle right after the cycle in which `adc_done` was accepted.
- R5: The correlated value is the signal sample minus the reference sample, with both 32-bit results treated as signed, computed in 33 bits so that it never overflows. For example, 0x7FFFFFFF minus 0x80000000 gives +4294967295.
- R6: Each iteration updates the filter as acc = acc + ((d - acc) >>> 4), where d is the correlated value and the shift is arithmetic. A difference of +5 therefore leaves a zero filter at zero, and a difference of -5 moves it to -1.
- R7: The filter is cleared at the start of every batch. A batch is 16 iterations, so each reported value depends only on that batch's 32 samples.
- R8: After the 16th update, `batch_valid` is high for exactly one cycle and `batch_value` (33-bit signed) carries the filter value. `batch_value` holds until the next report, and the next batch begins without any further input.
- R9: While `enable` is low, the block idles with `mux_sel`=0 and no strobes or valid pulses. Dropping `enable` in the middle of a batch aborts it and produces no result. Raising `enable` again starts a fresh batch from a cleared filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run gate; low aborts and idles |
| mux_sel | output | 1 | Multiplexer channel: 0 signal, 1 reference |
| adc_start | output | 1 | Start-conversion strobe |
| adc_stop | output | 1 | Stop-conversion strobe |
| adc_done | input | 1 | End-of-conversion indication |
| adc_result | input | 32 | Signed conversion result, valid with `adc_done` |
| batch_valid | output | 1 | One-cycle pulse at the end of a batch |
| batch_value | output | 33 | Signed filtered result of the last batch |

## Verification
A corrupted phase flag or iteration count shows up at the ports at the next `adc_start`: either the channel is wrong for that point in the sequence, or the batch ends early or late. A wrong count also shifts the time of the valid pulse and changes the reported value. A bad sample register or filter accumulator is only visible in `batch_value`, up to one batch (32 conversions) later. The bench therefore compares each reported value against an independently computed filter over stimuli with positive drift, negative values, full-scale extremes and truncation-sized differences. An abort case confirms that no stale state leaks into the next batch.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_START,
    ST_WAIT,
    ST_NEXT,
    ST_UPDATE,
    ST_REPORT
  } cds_state_t;

  typedef enum logic {
    PH_SIG = 1'b0,
    PH_REF = 1'b1
  } cds_phase_t;
endpackage

// File: rtl/cds_ctrl.sv
module cds_ctrl
  import cds_pkg::*;
#(
  parameter int BATCH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic adc_done,
  output logic mux_sel,
  output logic adc_start,
  output logic adc_stop,
  output logic cap_en,
  output logic cap_phase,
  output logic upd_en,
  output logic clr_en,
  output logic rpt_en
);
  localparam int ITER_W = (BATCH > 1) ? $clog2(BATCH) : 1;
  localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(BATCH - 1);

  cds_state_t        state;
  cds_phase_t        phase;
  logic [ITER_W-1:0] iter;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state     <= ST_IDLE;
      phase     <= PH_SIG;
      iter      <= '0;
      mux_sel   <= 1'b0;
      adc_start <= 1'b0;
      adc_stop  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase <= PH_SIG;
          iter  <= '0;
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          mux_sel <= phase;
          state   <= ST_START;
        end
        ST_START: begin
          adc_start <= 1'b1;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          adc_start <= 1'b0;
          if (adc_done) begin
            adc_stop <= 1'b1;
            state    <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          adc_stop <= 1'b0;
          if (phase == PH_SIG) begin
            phase <= PH_REF;
            state <= ST_SETUP;
          end else begin
            state <= ST_UPDATE;
          end
        end
        ST_UPDATE: begin
          phase <= PH_SIG;
          if (iter == ITER_LAST) begin
            iter  <= '0;
            state <= ST_REPORT;
          end else begin
            iter  <= iter + 1'b1;
            state <= ST_SETUP;
          end
        end
        ST_REPORT: state <= ST_SETUP;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cap_en    = (state == ST_WAIT) && adc_done && enable;
    cap_phase = phase;
    upd_en    = (state == ST_UPDATE) && enable;
    rpt_en    = (state == ST_REPORT) && enable;
    clr_en    = (state == ST_IDLE) || (state == ST_REPORT) || !enable;
  end
endmodule

// File: rtl/cds_sample_diff.sv
module cds_sample_diff #(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_en,
  input  logic                     cap_phase,
  input  logic [DATA_W-1:0]        sample_in,
  output logic signed [DATA_W:0]   diff
);
  localparam int NPH = 2;

  logic [DATA_W-1:0] held [NPH];

  for (genvar p = 0; p < NPH; p++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) begin
        held[p] <= '0;
      end else if (cap_en && (cap_phase == p[0])) begin
        held[p] <= sample_in;
      end
    end
  end

  logic signed [DATA_W:0] sig_ext;
  logic signed [DATA_W:0] ref_ext;

  always_comb begin
    sig_ext = $signed({held[0][DATA_W-1], held[0]});
    ref_ext = $signed({held[1][DATA_W-1], held[1]});
    diff    = sig_ext - ref_ext;
  end
endmodule

// File: rtl/cds_iir.sv
module cds_iir #(
  parameter int ACC_W = 33,
  parameter int SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_en,
  input  logic                    upd_en,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [ACC_W-1:0] acc_next;

  if (SHIFT == 0) begin : g_pass
    always_comb acc_next = din;
  end else begin : g_shift
    logic signed [ACC_W:0] delta;
    logic signed [ACC_W:0] step;
    always_comb begin
      delta    = $signed({din[ACC_W-1], din}) - $signed({acc[ACC_W-1], acc});
      step     = delta >>> SHIFT;
      acc_next = acc + step[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_en) begin
      acc <= '0;
    end else if (upd_en) begin
      acc <= acc_next;
    end
  end
endmodule

// File: rtl/cds_seq.sv
module cds_seq #(
  parameter int DATA_W = 32,
  parameter int SHIFT  = 4,
  parameter int BATCH  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  output logic                 mux_sel,
  output logic                 adc_start,
  output logic                 adc_stop,
  input  logic                 adc_done,
  input  logic [DATA_W-1:0]    adc_result,
  output logic                 batch_valid,
  output logic [DATA_W:0]      batch_value
);
  localparam int ACC_W = DATA_W + 1;

  logic cap_en, cap_phase, upd_en, clr_en, rpt_en;
  logic signed [ACC_W-1:0] diff;
  logic signed [ACC_W-1:0] acc;

  cds_ctrl #(.BATCH(BATCH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .adc_done  (adc_done),
    .mux_sel   (mux_sel),
    .adc_start (adc_start),
    .adc_stop  (adc_stop),
    .cap_en    (cap_en),
    .cap_phase (cap_phase),
    .upd_en    (upd_en),
    .clr_en    (clr_en),
    .rpt_en    (rpt_en)
  );

  cds_sample_diff #(.DATA_W(DATA_W)) u_diff (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .cap_phase (cap_phase),
    .sample_in (adc_result),
    .diff      (diff)
  );

  cds_iir #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_iir (
    .clk    (clk),
    .rst    (rst),
    .clr_en (clr_en),
    .upd_en (upd_en),
    .din    (diff),
    .acc    (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      batch_valid <= 1'b0;
      batch_value <= '0;
    end else begin
      batch_valid <= rpt_en;
      if (rpt_en) batch_value <= acc;
    end
  end
endmodule

// File: rtl/cds_seq_chk.sv
module cds_seq_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic mux_sel,
  input logic adc_start,
  input logic adc_stop,
  input logic adc_done,
  input logic batch_valid
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);                                             // R3
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
    adc_stop |=> !adc_stop);                                               // R4
  AST_STOP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    adc_stop |-> $past(adc_done));                                         // R4
  AST_MUX_SETTLED: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $stable(mux_sel));                                       // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    batch_valid |=> !batch_valid);                                         // R8
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!adc_start && !adc_stop && !batch_valid && !mux_sel));    // R9
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(adc_start && adc_stop));                                             // R3
endmodule

bind cds_seq cds_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .mux_sel     (mux_sel),
  .adc_start   (adc_start),
  .adc_stop    (adc_stop),
  .adc_done    (adc_done),
  .batch_valid (batch_valid)
);

// File: tb/tb_cds_seq.sv
module tb_cds_seq;
  localparam int DW = 32;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic mux_sel, adc_start, adc_stop, batch_valid;
  logic model_done = 1'b0;
  logic spur_done = 1'b0;
  logic adc_done;
  logic [DW-1:0] adc_result = '0;
  logic [DW:0] batch_value;

  assign adc_done = model_done | spur_done;
  always #2 clk = ~clk;

  cds_seq dut (
    .clk(clk), .rst(rst), .enable(enable),
    .mux_sel(mux_sel), .adc_start(adc_start), .adc_stop(adc_stop),
    .adc_done(adc_done), .adc_result(adc_result),
    .batch_valid(batch_valid), .batch_value(batch_value)
  );

  typedef struct {
    logic [DW-1:0] v;
    logic          sel;
    int            dly;
  } smp_t;

  smp_t   smp_q[$];
  longint exp_q[$];
  int checks = 0;
  int errors = 0;
  int valid_seen = 0;
  int stop_cnt = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void gen(input int kind, input int i, output logic [DW-1:0] s, output logic [DW-1:0] r);
    case (kind)
      0: begin s = 32'(12345 + 7 * i); r = 32'd200; end
      1: begin s = 32'(-50000);        r = 32'(30000 + i); end
      2: begin s = 32'h7FFF_FFFF;      r = 32'h8000_0000; end
      3: begin s = 32'h8000_0000;      r = 32'h7FFF_FFFF; end
      4: begin s = 32'd5;              r = 32'd0; end
      5: begin s = 32'd0;              r = 32'd5; end
      default: begin s = (i % 2 == 1) ? 32'd100000 : 32'(-100000); r = 32'(-3); end
    endcase
  endfunction

  // driver: queue samples and the expected batch result (R5, R6, R7)
  task automatic push_batch(input int kind);
    longint acc = 0;
    for (int i = 0; i < NB; i++) begin
      logic [DW-1:0] s, r;
      longint d;
      smp_t a, b;
      gen(kind, i, s, r);
      a.v = s; a.sel = 1'b0; a.dly = (i % 4) + 1;
      b.v = r; b.sel = 1'b1; b.dly = ((i + 2) % 5) + 1;
      smp_q.push_back(a);
      smp_q.push_back(b);
      d = longint'($signed(s)) - longint'($signed(r));
      acc = acc + ((d - acc) >>> 4);
    end
    exp_q.push_back(acc);
  endtask

  // ADC model: answers each start, checks channel order (R2) and stop timing (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && adc_start) begin
        smp_t it;
        if (smp_q.size() > 0) begin
          it = smp_q.pop_front();
          chk(mux_sel == it.sel, "R2 mux_sel at start", longint'(mux_sel), longint'(it.sel));
        end else begin
          it.v = '0; it.sel = mux_sel; it.dly = 1;
        end
        repeat (it.dly) begin
          @(negedge clk);
          if (enable) chk(!adc_start && mux_sel == it.sel, "R3 waiting for done", longint'(adc_start), 0);
        end
        adc_result = it.v;
        model_done = 1'b1;
        @(negedge clk);
        model_done = 1'b0;
        if (enable) chk(adc_stop == 1'b1, "R4 stop after done", longint'(adc_stop), 1);
      end
    end
  end

  // monitor: compare reported values (R8)
  always @(negedge clk) begin
    if (!rst) begin
      if (adc_stop) stop_cnt++;
      if (batch_valid) begin
        valid_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected valid", longint'($signed(batch_value)), 0);
        end else begin
          longint e;
          e = exp_q.pop_front();
          chk(longint'($signed(batch_value)) == e, "R6/R7 batch value", longint'($signed(batch_value)), e);
        end
      end
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        finish_run();
      end
    end
  end

  task automatic stop_and_flush;
    @(negedge clk);
    enable = 1'b0;
    repeat (8) @(negedge clk);
    smp_q.delete();
    exp_q.delete();
  endtask

  initial begin
    int vs;
    int sc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mux_sel == 1'b0, "R1 mux_sel", longint'(mux_sel), 0);
    chk(adc_start == 1'b0 && adc_stop == 1'b0, "R1 strobes", longint'({adc_start, adc_stop}), 0);
    chk(batch_valid == 1'b0, "R1 valid", longint'(batch_valid), 0);
    chk(batch_value == '0, "R1 value", longint'($signed(batch_value)), 0);

    // back-to-back batches with varied patterns (R5 R6 R7 R8)
    for (int k = 0; k < 7; k++) push_batch(k);
    @(negedge clk);
    enable = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    chk(valid_seen == 7, "R8 batch count", valid_seen, 7);
    stop_and_flush();

    // idle behaviour and ignored done (R9, R3)
    chk(mux_sel == 1'b0 && !adc_start && !adc_stop, "R9 idle outputs", longint'({mux_sel, adc_start, adc_stop}), 0);
    vs = valid_seen;
    spur_done = 1'b1;
    @(negedge clk);
    spur_done = 1'b0;
    repeat (5) @(negedge clk);
    chk(!adc_start && !adc_stop, "R3 done ignored when idle", longint'({adc_start, adc_stop}), 0);
    chk(valid_seen == vs, "R9 no valid while off", valid_seen, vs);

    // abort mid batch (R9) then a fresh batch from a cleared filter (R7)
    push_batch(2);
    @(negedge clk);
    enable = 1'b1;
    sc = stop_cnt;
    while (stop_cnt < sc + 11) @(negedge clk);
    vs = valid_seen;
    enable = 1'b0;
    repeat (40) @(negedge clk);
    chk(valid_seen == vs, "R9 no result after abort", valid_seen, vs);
    chk(mux_sel == 1'b0, "R9 mux_sel after abort", longint'(mux_sel), 0);
    smp_q.delete();
    exp_q.delete();
    push_batch(0);
    @(negedge clk);
    enable = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    chk(valid_seen == vs + 1, "R9 restart produced one result", valid_seen, vs + 1);
    stop_and_flush();
    finish_run();
  end
endmodule